// File: doc/BRIEF.md
# Coprocessor I/O Window Decoder

This block sits beside a small sound CPU and decodes its accesses to a sixteen-byte register window at 00F0h–00FFh of a 16-bit address space. Inside the window it keeps a control register, two scratch bytes, four host-to-CPU mailbox inputs with paired clears, four CPU-to-host mailbox outputs, and an index/data pair. The index/data pair reaches a 128-entry register file that lives outside the block. It drives the enables for three external timers and for a boot-ROM overlay at the top of memory.

Every CPU write is also passed on to the backing RAM, whether or not it lands in the window. Reads return data one cycle after the read strobe. For window addresses, a flag marks that this block drove the read data.

Top module: `io_window_decoder`

## Requirements
- R1: Every CPU write, inside or outside the window, raises `ram_we` for one cycle on the following clock. `ram_addr` and `ram_wdata` carry the address and byte of that write.
- R2: A write to 00F2h stores the full byte as the index. A read of 00F2h returns it. `rf_addr` shows its low 7 bits from the next cycle.
- R3: A read of 00F3h returns `rf_rdata` sampled in the read cycle. `rf_addr` is the index masked to 7 bits, so index 85h reads entry 05h.
- R4: A write to 00F3h raises `rf_we` for one cycle with the byte on `rf_wdata`, but only when the index is 7Fh or below. With a larger index the write is dropped.
- R5: A write to 00F1h (control) sets `timer_en[2:0]` from bits 2..0 and `rom_en` from bit 7, visible on the next cycle. After reset the timers are off and the overlay is on.
- R6: Control bit 4 written as 1 clears input ports 0 and 1. Bit 5 written as 1 clears ports 2 and 3. A clear wins over a host write to the same port in the same cycle.
- R7: 00F8h and 00F9h are read/write scratch bytes that each return the last value written.
- R8: CPU writes to 00F4h–00F7h set output ports 0–3 (`out_ports` byte i = port i). CPU reads of those addresses return the host-written input ports, which the output writes do not affect.
- R9: Reads of 00F0h, 00F1h and 00FAh–00FFh return 0 with `rd_hit` set. Reads outside the window return 0 with `rd_hit` clear. A write to 00F0h changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data, one cycle after strobe |
| rd_hit | output | 1 | Previous read was in the window |
| ram_we | output | 1 | Mirror write to backing RAM |
| ram_addr | output | 16 | Mirror write address |
| ram_wdata | output | 8 | Mirror write byte |
| rf_addr | output | 7 | Register-file index |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write byte |
| rf_rdata | input | 8 | Register-file read byte (combinational on rf_addr) |
| host_wr | input | 1 | Host mailbox write strobe |
| host_sel | input | 2 | Host mailbox port number |
| host_wdata | input | 8 | Host mailbox byte |
| out_ports | output | 32 | CPU-to-host mailboxes, byte i = port i |
| timer_en | output | 3 | Timer enables |
| rom_en | output | 1 | Boot-ROM overlay enable |

## Verification
The hardest case to reach is the index/data pair with an index above 7Fh. There the read path masks the index, the write path drops the access, and `rf_addr` looks the same as for the masked index. The stimulus sets index 85h, reads entry 05h of a preloaded register-file model, writes through the data port, and then selects index 05h directly to confirm that the entry kept its value. A second hard case is a host mailbox write that coincides with a control-register clear. The bench drives both in the same cycle.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam logic [3:0] OFS_TEST   = 4'h0;
  localparam logic [3:0] OFS_CTRL   = 4'h1;
  localparam logic [3:0] OFS_INDEX  = 4'h2;
  localparam logic [3:0] OFS_DATA   = 4'h3;
  localparam logic [3:0] OFS_PORT0  = 4'h4;
  localparam logic [3:0] OFS_LATCH0 = 4'h8;
  localparam int CTRL_ROM_BIT = 7;
  localparam int CTRL_CLR_LSB = 4;
endpackage

// File: rtl/io_ctrl_reg.sv
module io_ctrl_reg #(
  parameter int DW      = 8,
  parameter int NTIMER  = 3,
  parameter int NPAIR   = 2,
  parameter bit ROM_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [NTIMER-1:0] timer_en,
  output logic              rom_en,
  output logic [NPAIR-1:0]  clr_pair
);
  import io_win_pkg::*;

  // pair clears act in the cycle of the write
  assign clr_pair = wr_en ? wdata[CTRL_CLR_LSB +: NPAIR] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_en <= '0;
      rom_en   <= ROM_RST;
    end else if (wr_en) begin
      timer_en <= wdata[NTIMER-1:0];
      rom_en   <= wdata[CTRL_ROM_BIT];
    end
  end
endmodule

// File: rtl/io_port_bank.sv
module io_port_bank #(
  parameter int DW    = 8,
  parameter int NPORT = 4,
  localparam int PW    = $clog2(NPORT),
  localparam int NPAIR = NPORT / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic [PW-1:0]       host_sel,
  input  logic [DW-1:0]       host_wdata,
  input  logic                cpu_wr,
  input  logic [PW-1:0]       cpu_sel,
  input  logic [DW-1:0]       cpu_wdata,
  input  logic [NPAIR-1:0]    clr_pair,
  output logic [NPORT*DW-1:0] in_flat,
  output logic [NPORT*DW-1:0] out_flat
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [DW-1:0] in_q, out_q;
    always_ff @(posedge clk) begin
      if (rst) in_q <= '0;
      else if (clr_pair[i/2]) in_q <= '0;
      else if (host_wr && host_sel == PW'(i)) in_q <= host_wdata;
    end
    always_ff @(posedge clk) begin
      if (rst) out_q <= '0;
      else if (cpu_wr && cpu_sel == PW'(i)) out_q <= cpu_wdata;
    end
    assign in_flat[i*DW +: DW]  = in_q;
    assign out_flat[i*DW +: DW] = out_q;
  end
endmodule

// File: rtl/io_indirect.sv
module io_indirect #(
  parameter int DW    = 8,
  parameter int RF_AW = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_index,
  input  logic             wr_data,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    index_q,
  output logic [RF_AW-1:0] rf_addr,
  output logic             rf_we,
  output logic [DW-1:0]    rf_wdata
);
  logic in_range;
  assign in_range = (index_q[DW-1:RF_AW] == '0);
  assign rf_addr  = index_q[RF_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_we <= 1'b0;
      if (wr_index) index_q <= wdata;
      if (wr_data && in_range) begin
        rf_we    <= 1'b1;
        rf_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          RF_AW    = 7,
  parameter int          NPORT    = 4,
  parameter int          NTIMER   = 3,
  parameter int          NLATCH   = 2,
  parameter logic [15:0] WIN_BASE = 16'h00F0,
  localparam int PW = $clog2(NPORT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  input  logic                cpu_wr,
  input  logic                cpu_rd,
  output logic [DW-1:0]       cpu_rdata,
  output logic                rd_hit,
  output logic                ram_we,
  output logic [AW-1:0]       ram_addr,
  output logic [DW-1:0]       ram_wdata,
  output logic [RF_AW-1:0]    rf_addr,
  output logic                rf_we,
  output logic [DW-1:0]       rf_wdata,
  input  logic [DW-1:0]       rf_rdata,
  input  logic                host_wr,
  input  logic [PW-1:0]       host_sel,
  input  logic [DW-1:0]       host_wdata,
  output logic [NPORT*DW-1:0] out_ports,
  output logic [NTIMER-1:0]   timer_en,
  output logic                rom_en
);
  import io_win_pkg::*;

  logic          in_win;
  logic [3:0]    ofs;
  logic          is_port;
  logic [PW-1:0] port_idx;
  logic          wr_win;

  assign in_win   = (cpu_addr[AW-1:4] == WIN_BASE[AW-1:4]);
  assign ofs      = cpu_addr[3:0];
  assign is_port  = (ofs >= OFS_PORT0) && (ofs < OFS_PORT0 + 4'(NPORT));
  assign port_idx = PW'(ofs - OFS_PORT0);
  assign wr_win   = cpu_wr && in_win;

  // mirror of every write into backing RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= cpu_wr;
      if (cpu_wr) begin
        ram_addr  <= cpu_addr;
        ram_wdata <= cpu_wdata;
      end
    end
  end

  logic [NPORT/2-1:0] clr_pair;

  io_ctrl_reg #(.DW(DW), .NTIMER(NTIMER), .NPAIR(NPORT/2)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_win && ofs == OFS_CTRL),
    .wdata    (cpu_wdata),
    .timer_en (timer_en),
    .rom_en   (rom_en),
    .clr_pair (clr_pair)
  );

  logic [NPORT*DW-1:0] in_flat;

  io_port_bank #(.DW(DW), .NPORT(NPORT)) u_ports (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .cpu_wr     (wr_win && is_port),
    .cpu_sel    (port_idx),
    .cpu_wdata  (cpu_wdata),
    .clr_pair   (clr_pair),
    .in_flat    (in_flat),
    .out_flat   (out_ports)
  );

  logic [DW-1:0] index_q;

  io_indirect #(.DW(DW), .RF_AW(RF_AW)) u_ind (
    .clk      (clk),
    .rst      (rst),
    .wr_index (wr_win && ofs == OFS_INDEX),
    .wr_data  (wr_win && ofs == OFS_DATA),
    .wdata    (cpu_wdata),
    .index_q  (index_q),
    .rf_addr  (rf_addr),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata)
  );

  // scratch bytes
  logic [NLATCH*DW-1:0] latch_flat;
  for (genvar j = 0; j < NLATCH; j++) begin : g_latch
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_win && ofs == OFS_LATCH0 + 4'(j)) q <= cpu_wdata;
    end
    assign latch_flat[j*DW +: DW] = q;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      if (ofs == OFS_INDEX) rd_mux = index_q;
      else if (ofs == OFS_DATA) rd_mux = rf_rdata;
      else if (is_port) rd_mux = in_flat[port_idx*DW +: DW];
      else if (ofs >= OFS_LATCH0 && ofs < OFS_LATCH0 + 4'(NLATCH))
        rd_mux = latch_flat[(ofs - OFS_LATCH0)*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      rd_hit    <= 1'b0;
    end else begin
      rd_hit <= cpu_rd && in_win;
      if (cpu_rd) cpu_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/io_win_chk.sv
module io_win_chk #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          RF_AW    = 7,
  parameter int          NPORT    = 4,
  parameter int          NTIMER   = 3,
  parameter logic [15:0] WIN_BASE = 16'h00F0
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       cpu_addr,
  input logic [DW-1:0]       cpu_wdata,
  input logic                cpu_wr,
  input logic                ram_we,
  input logic [AW-1:0]       ram_addr,
  input logic [DW-1:0]       ram_wdata,
  input logic                rf_we,
  input logic [RF_AW-1:0]    rf_addr,
  input logic [NTIMER-1:0]   timer_en,
  input logic [NPORT*DW-1:0] in_flat
);
  // R1
  ram_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> ram_we && ram_addr == $past(cpu_addr) && ram_wdata == $past(cpu_wdata));

  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == WIN_BASE + 16'd2) |=> rf_addr == $past(cpu_wdata[RF_AW-1:0]));

  // R4
  rf_write_src_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(cpu_wr) && $past(cpu_addr) == WIN_BASE + 16'd3);

  // R5
  timer_en_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == WIN_BASE + 16'd1) |=> timer_en == $past(cpu_wdata[NTIMER-1:0]));

  // R6
  clear_low_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == WIN_BASE + 16'd1 && cpu_wdata[4]) |=> in_flat[2*DW-1:0] == '0);
endmodule

bind io_window_decoder io_win_chk #(
  .AW(AW), .DW(DW), .RF_AW(RF_AW), .NPORT(NPORT), .NTIMER(NTIMER), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rf_we(rf_we),
  .rf_addr(rf_addr), .timer_en(timer_en), .in_flat(in_flat)
);

// File: tb/sim_io_window_decoder.sv
`timescale 1ns/1ps
module sim_io_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        rd_hit, ram_we, rf_we, rom_en;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, rf_wdata, rf_rdata;
  logic [6:0]  rf_addr;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic [31:0] out_ports;
  logic [2:0]  timer_en;

  always #5 clk = ~clk;

  io_window_decoder u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .rd_hit(rd_hit), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .out_ports(out_ports), .timer_en(timer_en), .rom_en(rom_en)
  );

  // register file model outside the block
  logic [7:0] rf_mem [128];
  initial for (int i = 0; i < 128; i++) rf_mem[i] = 8'(i) ^ 8'h3C;
  assign rf_rdata = rf_mem[rf_addr];
  always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard for reads
  logic [8:0] exp_q[$];
  string      tag_q[$];
  bit         rd_seen = 0;
  always @(posedge clk) rd_seen <= cpu_rd;
  always @(negedge clk) begin
    if (rd_seen && !rst) begin
      if (exp_q.size() == 0) check("scoreboard", 0, 1);
      else check(tag_q.pop_front(), {rd_hit, cpu_rdata}, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic hit, input logic [7:0] exp, input string tag);
    exp_q.push_back({hit, exp}); tag_q.push_back(tag);
    cpu_addr = a; cpu_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic host(input logic [1:0] s, input logic [7:0] d);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R5 reset state
    check("R5 reset timer_en", timer_en, 0);
    check("R5 reset rom_en", rom_en, 1);
    check("R8 reset out_ports", out_ports, 0);
    check("R1 reset ram_we", ram_we, 0);
    check("R4 reset rf_we", rf_we, 0);
    rd(16'h00F8, 1, 8'h00, "R7 reset latch");

    // R1 mirror outside and inside the window
    wr(16'h1234, 8'hAB);
    check("R1 we", ram_we, 1); check("R1 addr", ram_addr, 16'h1234); check("R1 data", ram_wdata, 8'hAB);
    wr(16'h00F8, 8'h5A);
    check("R1 window addr", ram_addr, 16'h00F8); check("R1 window data", ram_wdata, 8'h5A);
    @(negedge clk); check("R1 one cycle", ram_we, 0);

    // R7 scratch bytes
    wr(16'h00F9, 8'hC3);
    rd(16'h00F9, 1, 8'hC3, "R7 F9");
    rd(16'h00F8, 1, 8'h5A, "R7 F8");

    // R5 control
    wr(16'h00F1, 8'h05);
    check("R5 timers", timer_en, 3'b101); check("R5 rom off", rom_en, 0);
    wr(16'h00F1, 8'h82);
    check("R5 timers2", timer_en, 3'b010); check("R5 rom on", rom_en, 1);

    // R8 ports
    host(0, 8'h11); host(1, 8'h22); host(2, 8'h33); host(3, 8'h44);
    wr(16'h00F4, 8'h91); wr(16'h00F5, 8'h92); wr(16'h00F6, 8'h93); wr(16'h00F7, 8'h94);
    check("R8 out_ports", out_ports, 32'h94939291);
    rd(16'h00F4, 1, 8'h11, "R8 in0");
    rd(16'h00F7, 1, 8'h44, "R8 in3");

    // R6 clears
    wr(16'h00F1, 8'h90);
    rd(16'h00F4, 1, 8'h00, "R6 clr p0");
    rd(16'h00F5, 1, 8'h00, "R6 clr p1");
    rd(16'h00F6, 1, 8'h33, "R6 keep p2");
    host(0, 8'h55);
    host_sel = 2'd2; host_wdata = 8'h77; host_wr = 1'b1;
    wr(16'h00F1, 8'hA0);
    rd(16'h00F6, 1, 8'h00, "R6 clear beats host");
    rd(16'h00F7, 1, 8'h00, "R6 clr p3");
    rd(16'h00F4, 1, 8'h55, "R6 keep p0");

    // R2/R3/R4 indirect
    wr(16'h00F2, 8'h25);
    check("R2 rf_addr", rf_addr, 7'h25);
    rd(16'h00F2, 1, 8'h25, "R2 index read");
    wr(16'h00F3, 8'h6E);
    check("R4 rf_we", rf_we, 1); check("R4 rf_wdata", rf_wdata, 8'h6E);
    @(negedge clk);
    rd(16'h00F3, 1, 8'h6E, "R3 data read");
    wr(16'h00F2, 8'h85);
    check("R3 masked", rf_addr, 7'h05);
    rd(16'h00F2, 1, 8'h85, "R2 full index");
    rd(16'h00F3, 1, 8'h05 ^ 8'h3C, "R3 masked read");
    wr(16'h00F3, 8'h99);
    check("R4 dropped", rf_we, 0);
    @(negedge clk);
    wr(16'h00F2, 8'h05);
    rd(16'h00F3, 1, 8'h05 ^ 8'h3C, "R4 entry kept");

    // R9 zero reads and ignored test register
    wr(16'h00F0, 8'h0A);
    check("R9 test no timer effect", timer_en, 3'b000);
    check("R9 test no rom effect", rom_en, 1);
    check("R9 test no port effect", out_ports, 32'h94939291);
    rd(16'h00F0, 1, 8'h00, "R9 F0");
    rd(16'h00F1, 1, 8'h00, "R9 F1");
    rd(16'h00FA, 1, 8'h00, "R9 FA");
    rd(16'h00FF, 1, 8'h00, "R9 FF");
    rd(16'h1234, 0, 8'h00, "R9 outside");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule